// File: doc/BRIEF.md
# Ring-Buffer Remote DMA Data Port

This block sits between a host data register and a local byte-addressed packet buffer. The host first loads a remote start address and a remote byte count. It then issues a series of accesses to one data port. Each access reads or writes the buffer at the current address. After the access, the address moves forward by the access size and the remaining count goes down by the same amount.

The address runs inside a ring that two registers bound, a ring-start and a ring-stop page pointer. When a step lands exactly on ring-stop, the address is reloaded from ring-start. When the count is used up, a sticky completion status bit is set. The interrupt request follows that bit through a mask.

Narrow accesses move a byte or a 16-bit word, as a configuration bit selects. A separate wide access always moves a 32-bit dword. Multi-byte data is little-endian. Writes stop once the count reaches zero. Reads never stop.

Top module: `rdma_ring_port`

## Requirements
- R1: A data-port access that is carried out advances the current address by its size: 1 for a byte, 2 for a word, 4 for a dword, modulo 2^ADDR_W.
- R2: When the advanced address equals ring-stop exactly, the current address becomes ring-start in that same update.
- R3: When the advanced address passes ring-stop without equalling it, no wrap is done.
- R4: When the remaining count is less than or equal to the access size, the count becomes zero. Otherwise the size is subtracted from it.
- R5: An access carried out while the count is at most its size sets the completion status bit (`dma_done`).
- R6: `irq` is high exactly when the completion status bit is set and the mask register bit 0 is set.
- R7: The completion status bit is sticky. A register write to the status select (6) with data bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged.
- R8: A data-port write while the count is zero is ignored: the buffer, the address and the count are left unchanged.
- R9: A data-port read while the count is zero still returns buffer data and still updates the address and the count.
- R10: For narrow accesses, bit 0 of the configuration register (select 4) picks the width: 1 means a 16-bit word and 0 means an 8-bit byte.
- R11: A wide access (`dp_wide`=1) always transfers 4 bytes and advances by 4, whatever the configuration bit holds.
- R12: Read data appears on `dp_rdata` with `dp_rvalid` one cycle after the read request. It is little-endian (byte at the address in bits 7:0) and zero-extended above the access size.
- R13: After reset, the address, count, start, stop, configuration, mask and status all hold zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 start, 1 stop, 2 address, 3 count, 4 config, 5 mask, 6 status clear |
| cfg_wdata | input | CNT_W | Register write data |
| dp_req | input | 1 | Data-port access strobe |
| dp_we | input | 1 | 1 = write access, 0 = read access |
| dp_wide | input | 1 | 1 = 32-bit dword access |
| dp_wdata | input | 32 | Write data, little-endian |
| dp_rdata | output | 32 | Read data, zero-extended |
| dp_rvalid | output | 1 | Read data valid |
| cur_addr | output | ADDR_W | Current remote address |
| cur_count | output | CNT_W | Remaining remote byte count |
| dma_done | output | 1 | Completion status bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W=8 and CNT_W=16. That gives a 256-byte buffer, so a reference copy of the whole memory fits in the bench and every read can be predicted. The narrow ring used (start 0x10, stop 0x20 or 0x21) puts exact-hit wraps and overshoot steps within a few accesses. Small counts such as 3 make the clamp and the zero-count gating on writes and reads reachable in two or three accesses.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
    typedef enum logic [2:0] {
        SEL_START = 3'd0,
        SEL_STOP  = 3'd1,
        SEL_ADDR  = 3'd2,
        SEL_COUNT = 3'd3,
        SEL_CFG   = 3'd4,
        SEL_MASK  = 3'd5,
        SEL_STAT  = 3'd6
    } reg_sel_e;

    localparam logic [2:0] SZ_BYTE  = 3'd1;
    localparam logic [2:0] SZ_WORD  = 3'd2;
    localparam logic [2:0] SZ_DWORD = 3'd4;

    function automatic logic [3:0] lanes_of(input logic [2:0] sz);
        case (sz)
            SZ_BYTE: lanes_of = 4'b0001;
            SZ_WORD: lanes_of = 4'b0011;
            default: lanes_of = 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/rdma_step.sv
module rdma_step #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] ring_start,
    input  logic [ADDR_W-1:0] ring_stop,
    input  logic [2:0]        size,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              exhausted
);
    logic [ADDR_W-1:0] stepped;
    logic [CNT_W-1:0]  size_c;

    always_comb begin
        stepped   = addr + ADDR_W'(size);
        nxt_addr  = (stepped == ring_stop) ? ring_start : stepped;
        size_c    = CNT_W'(size);
        exhausted = (cnt <= size_c);
        nxt_cnt   = exhausted ? '0 : (cnt - size_c);
    end
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [3:0]        be,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (we && be[i]) begin
                mem[addr + ADDR_W'(i)] <= wdata[8*i +: 8];
            end
            if (re) begin
                rdata[8*i +: 8] <= mem[addr + ADDR_W'(i)];
            end
        end
    end
endmodule

// File: rtl/rdma_ring_port.sv
module rdma_ring_port #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              dp_req,
    input  logic              dp_we,
    input  logic              dp_wide,
    input  logic [31:0]       dp_wdata,
    output logic [31:0]       dp_rdata,
    output logic              dp_rvalid,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_count,
    output logic              dma_done,
    output logic              irq
);
    import rdma_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] stop;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              word;
        logic              mask;
        logic              stat;
        logic              rvalid;
        logic [2:0]        rsize;
    } state_t;

    state_t            q_r, d_c;
    logic [2:0]        size_c;
    logic              take_c;
    logic [ADDR_W-1:0] nxt_addr;
    logic [CNT_W-1:0]  nxt_cnt;
    logic              exhausted;
    logic [31:0]       raw_rdata;
    logic              word_sel;
    logic [ADDR_W-1:0] ring_start;
    logic [ADDR_W-1:0] ring_stop;

    rdma_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
        .addr       (q_r.addr),
        .cnt        (q_r.cnt),
        .ring_start (q_r.start),
        .ring_stop  (q_r.stop),
        .size       (size_c),
        .nxt_addr   (nxt_addr),
        .nxt_cnt    (nxt_cnt),
        .exhausted  (exhausted)
    );

    rdma_buf #(.ADDR_W(ADDR_W)) u_buf (
        .clk   (clk),
        .we    (take_c && dp_we),
        .be    (lanes_of(size_c)),
        .re    (dp_req && !dp_we),
        .addr  (q_r.addr),
        .wdata (dp_wdata),
        .rdata (raw_rdata)
    );

    always_comb begin
        d_c      = q_r;
        size_c   = dp_wide ? SZ_DWORD : (q_r.word ? SZ_WORD : SZ_BYTE);
        take_c   = dp_req && !(dp_we && (q_r.cnt == '0));
        d_c.rvalid = dp_req && !dp_we;
        d_c.rsize  = size_c;
        if (take_c) begin
            d_c.addr = nxt_addr;
            d_c.cnt  = nxt_cnt;
            if (exhausted) begin
                d_c.stat = 1'b1;
            end
        end
        if (cfg_we) begin
            case (reg_sel_e'(cfg_sel))
                SEL_START: d_c.start = cfg_wdata[ADDR_W-1:0];
                SEL_STOP:  d_c.stop  = cfg_wdata[ADDR_W-1:0];
                SEL_ADDR:  d_c.addr  = cfg_wdata[ADDR_W-1:0];
                SEL_COUNT: d_c.cnt   = cfg_wdata;
                SEL_CFG:   d_c.word  = cfg_wdata[0];
                SEL_MASK:  d_c.mask  = cfg_wdata[0];
                SEL_STAT:  if (cfg_wdata[0] && !(take_c && exhausted)) d_c.stat = 1'b0;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else begin
            q_r <= d_c;
        end
    end

    always_comb begin
        case (q_r.rsize)
            SZ_BYTE: dp_rdata = {24'b0, raw_rdata[7:0]};
            SZ_WORD: dp_rdata = {16'b0, raw_rdata[15:0]};
            default: dp_rdata = raw_rdata;
        endcase
    end

    assign dp_rvalid  = q_r.rvalid;
    assign cur_addr   = q_r.addr;
    assign cur_count  = q_r.cnt;
    assign dma_done   = q_r.stat;
    assign irq        = q_r.stat & q_r.mask;
    assign word_sel   = q_r.word;
    assign ring_start = q_r.start;
    assign ring_stop  = q_r.stop;
endmodule

// File: rtl/rdma_ring_port_chk.sv
module rdma_ring_port_chk #(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              dp_req,
    input logic              dp_we,
    input logic              dp_wide,
    input logic              dp_rvalid,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_count,
    input logic              dma_done,
    input logic              irq,
    input logic              word_sel,
    input logic [ADDR_W-1:0] ring_start,
    input logic [ADDR_W-1:0] ring_stop
);
    // R1
    byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && !dp_wide && !word_sel && !cfg_we && !(dp_we && cur_count == '0)
        && ((cur_addr + 1'b1) != ring_stop)
        |=> cur_addr == $past(cur_addr) + 1'b1);

    // R2
    exact_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && !dp_wide && !word_sel && !cfg_we && !(dp_we && cur_count == '0)
        && ((cur_addr + 1'b1) == ring_stop)
        |=> cur_addr == $past(ring_start));

    // R4
    word_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && !dp_wide && word_sel && !cfg_we && cur_count <= CNT_W'(2)
        |=> cur_count == '0);

    // R5
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && !cfg_we && !dp_we && !dp_wide && !word_sel && cur_count <= CNT_W'(1)
        |=> dma_done);

    // R6
    irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_done |-> !irq);

    // R8
    dropped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && dp_we && !cfg_we && cur_count == '0
        |=> $stable(cur_addr) && $stable(cur_count));

    // R11
    dword_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && dp_wide && !cfg_we && cur_count > CNT_W'(4)
        |=> cur_count == $past(cur_count) - CNT_W'(4));

    // R12
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && !dp_we |=> dp_rvalid);
endmodule

bind rdma_ring_port rdma_ring_port_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .dp_req     (dp_req),
    .dp_we      (dp_we),
    .dp_wide    (dp_wide),
    .dp_rvalid  (dp_rvalid),
    .cur_addr   (cur_addr),
    .cur_count  (cur_count),
    .dma_done   (dma_done),
    .irq        (irq),
    .word_sel   (word_sel),
    .ring_start (ring_start),
    .ring_stop  (ring_stop)
);

// File: tb/test_rdma_ring_port.sv
`timescale 1ns/1ps
module test_rdma_ring_port;
    localparam int AW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          dp_req = 1'b0;
    logic          dp_we = 1'b0;
    logic          dp_wide = 1'b0;
    logic [31:0]   dp_wdata = '0;
    logic [31:0]   dp_rdata;
    logic          dp_rvalid;
    logic [AW-1:0] cur_addr;
    logic [CW-1:0] cur_count;
    logic          dma_done;
    logic          irq;

    rdma_ring_port #(.ADDR_W(AW), .CNT_W(CW)) i_rdma_ring_port (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dp_req(dp_req), .dp_we(dp_we),
        .dp_wide(dp_wide), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
        .dp_rvalid(dp_rvalid), .cur_addr(cur_addr), .cur_count(cur_count),
        .dma_done(dma_done), .irq(irq)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0]    m_mem [256];
    logic [AW-1:0] m_start = '0, m_stop = '0, m_addr = '0;
    int            m_cnt = 0;
    bit            m_word = 0, m_mask = 0, m_stat = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic check_state(string req);
        chk({req, " addr"}, 32'(cur_addr), 32'(m_addr));
        chk({req, " count"}, 32'(cur_count), 32'(m_cnt));
        chk({req, " done"}, 32'(dma_done), 32'(m_stat));
        chk({req, " irq"}, 32'(irq), 32'(m_stat & m_mask));
    endtask

    task automatic cfg_write(int sel, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_wdata = CW'(val);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: m_start = AW'(val);
            1: m_stop  = AW'(val);
            2: m_addr  = AW'(val);
            3: m_cnt   = val;
            4: m_word  = val[0];
            5: m_mask  = val[0];
            6: if (val[0]) m_stat = 0;
            default: ;
        endcase
    endtask

    task automatic access(bit we, bit wide, logic [31:0] wd, string req);
        int sz = wide ? 4 : (m_word ? 2 : 1);
        bit take = !(we && m_cnt == 0);
        logic [31:0] exp = '0;
        if (!we) begin
            for (int i = 0; i < sz; i++) exp[8*i +: 8] = m_mem[8'(m_addr + AW'(i))];
            exp_q.push_back(exp);
            tag_q.push_back(req);
        end
        if (take) begin
            if (we) for (int i = 0; i < sz; i++) m_mem[8'(m_addr + AW'(i))] = wd[8*i +: 8];
            m_addr = m_addr + AW'(sz);
            if (m_addr == m_stop) m_addr = m_start;
            if (m_cnt <= sz) begin m_cnt = 0; m_stat = 1; end
            else m_cnt = m_cnt - sz;
        end
        @(negedge clk);
        dp_req = 1'b1; dp_we = we; dp_wide = wide; dp_wdata = wd;
        @(negedge clk);
        dp_req = 1'b0; dp_we = 1'b0; dp_wide = 1'b0;
    endtask

    // monitor: pops the scoreboard when read data appears
    always @(negedge clk) begin
        if (rst_n && dp_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R12 unexpected read actual=0x%0h expected=none", dp_rdata);
            end else begin
                chk(tag_q.pop_front(), dp_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_state("R13 reset");
        chk("R13 rvalid", 32'(dp_rvalid), 0);

        cfg_write(0, 'h10); cfg_write(1, 'h20); cfg_write(2, 'h10);
        cfg_write(3, 'h40); cfg_write(4, 0); cfg_write(5, 0);
        // R1 R10: byte mode steps by one
        access(1, 0, 32'hA1, "R10"); access(1, 0, 32'hA2, "R10");
        access(1, 0, 32'hA3, "R10"); access(1, 0, 32'hA4, "R10");
        check_state("R1 byte");
        // R10: word mode steps by two
        cfg_write(4, 1);
        access(1, 0, 32'hB2B1, "R10");
        check_state("R10 word");
        // R2: exact hit on stop wraps to start
        cfg_write(2, 'h1E);
        access(1, 0, 32'hC2C1, "R2");
        check_state("R2 wrap");
        // R3: stepping past stop does not wrap
        cfg_write(1, 'h21); cfg_write(2, 'h20);
        access(1, 0, 32'hD2D1, "R3");
        check_state("R3 overshoot");
        cfg_write(1, 'h20);
        // R11: dword write ignores word bit
        cfg_write(2, 'h30);
        access(1, 1, 32'h44332211, "R11");
        check_state("R11 dword");
        cfg_write(2, 'h44);
        access(1, 1, 32'h88776655, "R11");
        // R12: little-endian reads, zero-extended
        cfg_write(2, 'h30);
        access(0, 1, 0, "R12 dword read");
        access(0, 0, 0, "R12 word read");
        cfg_write(4, 0);
        access(0, 0, 0, "R12 byte read");
        check_state("R12 after reads");
        // R4 R5 R6: clamp, completion, masked interrupt
        cfg_write(4, 1); cfg_write(2, 'h40); cfg_write(3, 3);
        access(1, 0, 32'hE2E1, "R4");
        check_state("R4 partial");
        access(1, 0, 32'hE4E3, "R4");
        check_state("R5 clamp done");
        chk("R6 masked irq", 32'(irq), 0);
        cfg_write(5, 1);
        chk("R6 irq", 32'(irq), 1);
        // R8: write at zero count ignored
        access(1, 0, 32'hDEAD, "R8");
        check_state("R8 dropped");
        // R9: read at zero count proceeds, returns untouched data
        access(0, 0, 0, "R9 read at zero");
        check_state("R9 read update");
        // R7: sticky status, write-one-to-clear
        cfg_write(6, 0);
        check_state("R7 sticky");
        cfg_write(6, 1);
        check_state("R7 cleared");
        chk("R7 irq low", 32'(irq), 0);
        repeat (3) @(negedge clk);
        chk("R12 scoreboard drained", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule